// File: doc/BRIEF.md
# Multi-channel ADC scan sequencer

This block produces the timing for a multiplexed analog input path that converts several channels in turn. Software programs four counts before a run: how many timebase ticks separate the starts of two scans, how many ticks separate two conversions inside one scan, how many channels each scan visits, and how many scans the run holds. A start trigger begins the run. If a delay is enabled, the block first waits a programmed number of ticks.

During a run the block issues a one-clock conversion strobe for each channel. Alongside each strobe it drives the channel index that the multiplexer should select. It marks the first conversion of every scan with a scan-start pulse. It also drives two level flags, one for the current scan and one for the whole run. All counting is in ticks of a timebase enable. That enable is chosen from four sources: an internal divider, an external pin, and two timer outputs. Each source must be a single-clock enable that is already synchronous to `clk`.

The converter, sample storage and bus access sit outside this block. Every output is a plain level or pulse. There is no handshake, so nothing back-pressures the sequencer.

Top module: `scan_seq_top`

## Requirements
- R1: `tb_sel` picks the timebase: 0 selects `tick_int`, 1 selects `tick_ext`, 2 selects `tick_tmr_a` and 3 selects `tick_tmr_b`. Only ticks of the selected source advance the timing.
- R2: If any of `scan_intv`, `samp_intv`, `chan_cnt` or `scan_cnt` is zero, the configuration is invalid. It is also invalid if `dly_en` is 1 while `dly_cnt` is zero. From the next clock `cfg_err` is 1. While `cfg_err` is 1 or the configuration is invalid, a start is ignored and `acq_busy` stays 0.
- R3: With `dly_en`=0, a start sampled in cycle T raises `acq_busy` in cycle T. The first strobe comes on the first selected tick after cycle T.
- R4: With `dly_en`=1, the first strobe comes on the (`dly_cnt`+1)-th selected tick after the start cycle. `acq_busy` is 1 throughout the wait.
- R5: Each scan issues `chan_cnt` strobes spaced `samp_intv` ticks apart. During the k-th strobe of a scan (k counted from 0), `chan_idx` equals k.
- R6: `scan_start` is 1 exactly in the cycle of the first strobe of each scan.
- R7: Consecutive scan starts are max(`scan_intv`, (`chan_cnt`-1)*`samp_intv`+1) ticks apart.
- R8: A run holds exactly `scan_cnt` scans. `acq_busy` falls in the clock after the last strobe.
- R9: `scan_busy` is 1 from the first strobe of a scan through its last strobe, both included, and 0 at all other times.
- R10: A start that arrives while `acq_busy` is 1 is ignored. The counts are captured at the accepted start, so changing them mid-run has no effect on that run.
- R11: One clock after `abort` is sampled, `conv_strobe`, `scan_busy` and `acq_busy` are all 0. The block is then idle and accepts a new start.
- R12: `conv_strobe` and `scan_start` are high for one clock per event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_int | input | 1 | Internal timebase enable |
| tick_ext | input | 1 | External-pin timebase enable (already synchronised) |
| tick_tmr_a | input | 1 | Timer A timebase enable |
| tick_tmr_b | input | 1 | Timer B timebase enable |
| tb_sel | input | 2 | Timebase source select |
| scan_intv | input | CNT_W | Ticks between scan starts |
| samp_intv | input | CNT_W | Ticks between conversions in a scan |
| chan_cnt | input | CH_W | Channels per scan |
| scan_cnt | input | SCN_W | Scans per run |
| dly_en | input | 1 | Enable post-trigger delay |
| dly_cnt | input | CNT_W | Delay length in ticks |
| start | input | 1 | Start trigger |
| abort | input | 1 | Software abort |
| conv_strobe | output | 1 | Conversion strobe |
| scan_start | output | 1 | First conversion of a scan |
| scan_busy | output | 1 | Scan in progress |
| acq_busy | output | 1 | Run in progress |
| chan_idx | output | CH_W | Channel for the current conversion |
| cfg_err | output | 1 | Invalid configuration flag |

## Verification
Two events can fall in the same cycle here. The first is an abort that arrives on the very tick that would issue a conversion strobe. The second is a fresh start that arrives while a strobe is still issuing. The bench runs the timebase every clock with one-tick sampling, so every cycle of a scan is a strobe cycle, and it drops `abort` into the middle of that stream. It judges the result by requiring that no strobe and no busy flag appear in the following cycle, and that no strobe at all appears afterwards. A mid-run retrigger, combined with a changed channel count, must leave the recorded strobe times and channel indices exactly as the first start predicted.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_WAIT = 2'd1,
    SQ_RUN  = 2'd2
  } sq_state_t;
endpackage

// File: rtl/scan_tick_mux.sv
module scan_tick_mux #(
  parameter int N_SRC = 4,
  localparam int SEL_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0] src,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [N_SRC-1:0] hit;
  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    assign hit[i] = src[i] && (sel == SEL_W'(i));
  end
  assign tick = |hit;
endmodule

// File: rtl/scan_cfg_check.sv
module scan_cfg_check #(
  parameter int CNT_W = 16,
  parameter int CH_W  = 4,
  parameter int SCN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] scan_intv,
  input  logic [CNT_W-1:0] samp_intv,
  input  logic [CH_W-1:0]  chan_cnt,
  input  logic [SCN_W-1:0] scan_cnt,
  input  logic             dly_en,
  input  logic [CNT_W-1:0] dly_cnt,
  output logic             cfg_ok,
  output logic             err_q
);
  logic bad;
  always_comb begin
    bad = (scan_intv == '0) || (samp_intv == '0) || (chan_cnt == '0) ||
          (scan_cnt == '0) || (dly_en && (dly_cnt == '0));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= bad;
  end

  // a start needs both the present and the flagged view to be clean
  assign cfg_ok = !bad && !err_q;
endmodule

// File: rtl/scan_seq_core.sv
module scan_seq_core
  import scan_seq_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int CH_W  = 4,
  parameter int SCN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             start,
  input  logic             abort,
  input  logic             cfg_ok,
  input  logic [CNT_W-1:0] scan_intv,
  input  logic [CNT_W-1:0] samp_intv,
  input  logic [CH_W-1:0]  chan_cnt,
  input  logic [SCN_W-1:0] scan_cnt,
  input  logic             dly_en,
  input  logic [CNT_W-1:0] dly_cnt,
  output logic             conv_o,
  output logic             sstart_o,
  output logic             scan_busy_o,
  output logic             acq_busy_o,
  output logic [CH_W-1:0]  chan_o
);
  sq_state_t        state;
  logic [CNT_W-1:0] s_scan, s_samp;
  logic [CH_W-1:0]  s_chan;
  logic [CNT_W-1:0] dly_ctr, scan_tmr, samp_tmr;
  logic [SCN_W-1:0] scans_left;
  logic [CH_W-1:0]  chan_q;
  logic             in_scan_q, conv_q, sstart_q, run_q;

  logic            tick_run, fire_first, fire_next, fire_last;
  logic [CH_W-1:0] nxt_idx;

  always_comb begin
    nxt_idx    = chan_q + 1'b1;
    tick_run   = (state == SQ_RUN) && tick && !abort;
    fire_first = tick_run && !in_scan_q && (scan_tmr == '0);
    fire_next  = tick_run && in_scan_q && (samp_tmr == '0);
    fire_last  = (fire_first && (s_chan == CH_W'(1))) ||
                 (fire_next && (nxt_idx == s_chan - 1'b1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= SQ_IDLE;
      s_scan     <= '0;
      s_samp     <= '0;
      s_chan     <= '0;
      dly_ctr    <= '0;
      scan_tmr   <= '0;
      samp_tmr   <= '0;
      scans_left <= '0;
      chan_q     <= '0;
      in_scan_q  <= 1'b0;
      conv_q     <= 1'b0;
      sstart_q   <= 1'b0;
      run_q      <= 1'b0;
    end else begin
      conv_q   <= 1'b0;
      sstart_q <= 1'b0;
      if (abort) begin
        state     <= SQ_IDLE;
        run_q     <= 1'b0;
        in_scan_q <= 1'b0;
      end else begin
        unique case (state)
          SQ_IDLE: begin
            if (start && cfg_ok && !conv_q) begin
              s_scan     <= scan_intv;
              s_samp     <= samp_intv;
              s_chan     <= chan_cnt;
              scans_left <= scan_cnt;
              scan_tmr   <= '0;
              in_scan_q  <= 1'b0;
              run_q      <= 1'b1;
              dly_ctr    <= dly_cnt;
              state      <= dly_en ? SQ_WAIT : SQ_RUN;
            end
          end
          SQ_WAIT: begin
            if (tick) begin
              if (dly_ctr == CNT_W'(1)) state <= SQ_RUN;
              else                      dly_ctr <= dly_ctr - 1'b1;
            end
          end
          SQ_RUN: begin
            if (tick && (scan_tmr != '0)) scan_tmr <= scan_tmr - 1'b1;
            if (fire_first) begin
              conv_q    <= 1'b1;
              sstart_q  <= 1'b1;
              chan_q    <= '0;
              scan_tmr  <= s_scan - 1'b1;
              samp_tmr  <= s_samp - 1'b1;
              in_scan_q <= (s_chan != CH_W'(1));
            end else if (fire_next) begin
              conv_q   <= 1'b1;
              chan_q   <= nxt_idx;
              samp_tmr <= s_samp - 1'b1;
              if (fire_last) in_scan_q <= 1'b0;
            end else if (tick && in_scan_q) begin
              samp_tmr <= samp_tmr - 1'b1;
            end
            if (fire_last) begin
              if (scans_left == SCN_W'(1)) begin
                state <= SQ_IDLE;
                run_q <= 1'b0;
              end else begin
                scans_left <= scans_left - 1'b1;
              end
            end
          end
          default: state <= SQ_IDLE;
        endcase
      end
    end
  end

  assign conv_o      = conv_q;
  assign sstart_o    = sstart_q;
  assign chan_o      = chan_q;
  assign scan_busy_o = in_scan_q | conv_q;
  assign acq_busy_o  = run_q | conv_q;
endmodule

// File: rtl/scan_seq_top.sv
module scan_seq_top #(
  parameter int CNT_W = 16,
  parameter int CH_W  = 4,
  parameter int SCN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_int,
  input  logic             tick_ext,
  input  logic             tick_tmr_a,
  input  logic             tick_tmr_b,
  input  logic [1:0]       tb_sel,
  input  logic [CNT_W-1:0] scan_intv,
  input  logic [CNT_W-1:0] samp_intv,
  input  logic [CH_W-1:0]  chan_cnt,
  input  logic [SCN_W-1:0] scan_cnt,
  input  logic             dly_en,
  input  logic [CNT_W-1:0] dly_cnt,
  input  logic             start,
  input  logic             abort,
  output logic             conv_strobe,
  output logic             scan_start,
  output logic             scan_busy,
  output logic             acq_busy,
  output logic [CH_W-1:0]  chan_idx,
  output logic             cfg_err
);
  logic tick, cfg_ok;

  scan_tick_mux #(.N_SRC(4)) u_mux (
    .src  ({tick_tmr_b, tick_tmr_a, tick_ext, tick_int}),
    .sel  (tb_sel),
    .tick (tick)
  );

  scan_cfg_check #(.CNT_W(CNT_W), .CH_W(CH_W), .SCN_W(SCN_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .scan_intv (scan_intv),
    .samp_intv (samp_intv),
    .chan_cnt  (chan_cnt),
    .scan_cnt  (scan_cnt),
    .dly_en    (dly_en),
    .dly_cnt   (dly_cnt),
    .cfg_ok    (cfg_ok),
    .err_q     (cfg_err)
  );

  scan_seq_core #(.CNT_W(CNT_W), .CH_W(CH_W), .SCN_W(SCN_W)) u_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .start       (start),
    .abort       (abort),
    .cfg_ok      (cfg_ok),
    .scan_intv   (scan_intv),
    .samp_intv   (samp_intv),
    .chan_cnt    (chan_cnt),
    .scan_cnt    (scan_cnt),
    .dly_en      (dly_en),
    .dly_cnt     (dly_cnt),
    .conv_o      (conv_strobe),
    .sstart_o    (scan_start),
    .scan_busy_o (scan_busy),
    .acq_busy_o  (acq_busy),
    .chan_o      (chan_idx)
  );
endmodule

// File: rtl/scan_seq_chk.sv
module scan_seq_chk #(
  parameter int CH_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            abort,
  input logic            cfg_err,
  input logic            conv_strobe,
  input logic            scan_start,
  input logic            scan_busy,
  input logic            acq_busy,
  input logic [CH_W-1:0] chan_idx
);
  p_first_idx_r6: assert property (@(posedge clk) disable iff (!rst_n)
    scan_start |-> (conv_strobe && chan_idx == '0));

  p_strobe_in_scan_r9: assert property (@(posedge clk) disable iff (!rst_n)
    conv_strobe |-> (scan_busy && acq_busy));

  p_scan_in_acq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    scan_busy |-> acq_busy);

  p_idx_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_strobe && !scan_start) |-> (chan_idx == CH_W'($past(chan_idx) + 1'b1)));

  p_abort_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!acq_busy && !scan_busy && !conv_strobe));

  p_err_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_err && !acq_busy) |=> !acq_busy);

  p_rise_on_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acq_busy) |-> $past(start));
endmodule

bind scan_seq_top scan_seq_chk #(.CH_W(CH_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .abort       (abort),
  .cfg_err     (cfg_err),
  .conv_strobe (conv_strobe),
  .scan_start  (scan_start),
  .scan_busy   (scan_busy),
  .acq_busy    (acq_busy),
  .chan_idx    (chan_idx)
);

// File: tb/test_scan_seq_top.sv
`timescale 1ns/1ps
module test_scan_seq_top;
  localparam int CNT_W = 16;
  localparam int CH_W  = 4;
  localparam int SCN_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_int = 1'b0, tick_ext = 1'b0, tick_tmr_a = 1'b0, tick_tmr_b = 1'b0;
  logic [1:0] tb_sel = 2'd0;
  logic [CNT_W-1:0] scan_intv = 16'd8, samp_intv = 16'd2, dly_cnt = 16'd1;
  logic [CH_W-1:0] chan_cnt = 4'd3;
  logic [SCN_W-1:0] scan_cnt = 16'd3;
  logic dly_en = 1'b0, start = 1'b0, abort = 1'b0;
  logic conv_strobe, scan_start, scan_busy, acq_busy, cfg_err;
  logic [CH_W-1:0] chan_idx;

  always #4 clk = ~clk;

  scan_seq_top #(.CNT_W(CNT_W), .CH_W(CH_W), .SCN_W(SCN_W)) i_scan_seq_top (
    .clk(clk), .rst_n(rst_n), .tick_int(tick_int), .tick_ext(tick_ext),
    .tick_tmr_a(tick_tmr_a), .tick_tmr_b(tick_tmr_b), .tb_sel(tb_sel),
    .scan_intv(scan_intv), .samp_intv(samp_intv), .chan_cnt(chan_cnt),
    .scan_cnt(scan_cnt), .dly_en(dly_en), .dly_cnt(dly_cnt), .start(start),
    .abort(abort), .conv_strobe(conv_strobe), .scan_start(scan_start),
    .scan_busy(scan_busy), .acq_busy(acq_busy), .chan_idx(chan_idx),
    .cfg_err(cfg_err)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // timebase sources, each a periodic single-clock enable
  int ph = 0;
  int per_int = 1, per_ext = 1, per_ta = 1, per_tb = 1;
  always @(negedge clk) begin
    ph <= ph + 1;
    tick_int   <= (ph % per_int) == 0;
    tick_ext   <= (ph % per_ext) == 0;
    tick_tmr_a <= (ph % per_ta) == 0;
    tick_tmr_b <= (ph % per_tb) == 0;
  end

  // event log
  int ev_t[64];
  int ev_ch[64];
  int ev_ss[64];
  int n_ev = 0, busy_cyc = 0, acq_cyc = 0, ss_cyc = 0;
  always @(negedge clk) begin
    if (conv_strobe) begin
      if (n_ev < 64) begin
        ev_t[n_ev]  = cyc;
        ev_ch[n_ev] = int'(chan_idx);
        ev_ss[n_ev] = int'(scan_start);
      end
      n_ev = n_ev + 1;
    end
    if (scan_busy)  busy_cyc = busy_cyc + 1;
    if (acq_busy)   acq_cyc = acq_cyc + 1;
    if (scan_start) ss_cyc = ss_cyc + 1;
  end

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_log();
    n_ev = 0; busy_cyc = 0; acq_cyc = 0; ss_cyc = 0;
  endtask

  task automatic trig(output int t);
    @(negedge clk);
    start = 1'b1;
    t = cyc + 1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000 && acq_busy; i++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic set_cfg(input int si, input int sp, input int ch, input int ns,
                         input bit de, input int dc);
    scan_intv = CNT_W'(si); samp_intv = CNT_W'(sp); chan_cnt = CH_W'(ch);
    scan_cnt = SCN_W'(ns); dly_en = de; dly_cnt = CNT_W'(dc);
    repeat (3) @(negedge clk);
  endtask

  // expected strobe pattern with a tick every clock
  task automatic expect_run(input int t, input int d, input int ch, input int sp,
                            input int si, input int ns, input string tag);
    int per, last;
    per = ((ch - 1) * sp + 1 > si) ? (ch - 1) * sp + 1 : si;
    chk({tag, " R8 strobe count"}, n_ev, ns * ch);
    chk({tag, " R12 scan_start cycles"}, ss_cyc, ns);
    for (int s = 0; s < ns; s++) begin
      for (int j = 0; j < ch; j++) begin
        int k;
        k = s * ch + j;
        if (k < 64 && k < n_ev) begin
          chk({tag, " R5/R7 strobe time"}, ev_t[k], t + 1 + d + s * per + j * sp);
          chk({tag, " R5 chan_idx"}, ev_ch[k], j);
          chk({tag, " R6 scan_start"}, ev_ss[k], (j == 0) ? 1 : 0);
        end
      end
    end
    last = t + 1 + d + (ns - 1) * per + (ch - 1) * sp;
    chk({tag, " R9 scan_busy cycles"}, busy_cyc, ns * ((ch - 1) * sp + 1));
    chk({tag, " R8 acq_busy cycles"}, acq_cyc, last - t + 1);
    chk({tag, " R8 idle after"}, int'(acq_busy), 0);
  endtask

  task automatic t_reset();
    chk("R11 reset conv_strobe", int'(conv_strobe), 0);
    chk("R11 reset acq_busy", int'(acq_busy), 0);
    chk("R9 reset scan_busy", int'(scan_busy), 0);
    chk("R5 reset chan_idx", int'(chan_idx), 0);
    chk("R2 reset cfg_err", int'(cfg_err), 0);
  endtask

  task automatic t_post_trigger();
    int t;
    set_cfg(8, 2, 3, 3, 1'b0, 1);
    clear_log();
    trig(t);
    chk("R3 acq_busy at start", int'(acq_busy), 1);
    wait_idle();
    expect_run(t, 0, 3, 2, 8, 3, "R3 post");
  endtask

  task automatic t_delay();
    int t;
    set_cfg(4, 1, 2, 2, 1'b1, 5);
    clear_log();
    trig(t);
    wait_idle();
    expect_run(t, 5, 2, 1, 4, 2, "R4 delay");
  endtask

  task automatic t_overrun();
    int t;
    set_cfg(2, 1, 4, 2, 1'b0, 1);
    clear_log();
    trig(t);
    wait_idle();
    expect_run(t, 0, 4, 1, 2, 2, "R7 overrun");
  endtask

  task automatic t_single_chan();
    int t;
    set_cfg(1, 1, 1, 4, 1'b0, 1);
    clear_log();
    trig(t);
    wait_idle();
    expect_run(t, 0, 1, 1, 1, 4, "R7 one-chan");
  endtask

  task automatic t_cfg_err();
    int t;
    set_cfg(8, 2, 3, 0, 1'b0, 1);
    chk("R2 zero scan count flags", int'(cfg_err), 1);
    clear_log();
    trig(t);
    repeat (20) @(negedge clk);
    chk("R2 no strobe when invalid", n_ev, 0);
    chk("R2 acq_busy stays low", acq_cyc, 0);
    set_cfg(8, 0, 3, 2, 1'b0, 1);
    chk("R2 zero sample interval flags", int'(cfg_err), 1);
    set_cfg(8, 2, 3, 2, 1'b1, 0);
    chk("R2 zero delay flags", int'(cfg_err), 1);
    trig(t);
    repeat (20) @(negedge clk);
    chk("R2 no strobe with zero delay", n_ev, 0);
    set_cfg(8, 2, 3, 2, 1'b0, 1);
    chk("R2 flag clears", int'(cfg_err), 0);
  endtask

  task automatic t_retrig();
    int t;
    set_cfg(5, 1, 2, 2, 1'b0, 1);
    clear_log();
    trig(t);
    @(negedge clk);
    chan_cnt = 4'd5;
    scan_cnt = 16'd7;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_idle();
    expect_run(t, 0, 2, 1, 5, 2, "R10 retrigger");
  endtask

  task automatic t_abort();
    int t, seen;
    set_cfg(4, 1, 4, 10, 1'b0, 1);
    clear_log();
    trig(t);
    repeat (5) @(negedge clk);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    chk("R11 strobe low after abort", int'(conv_strobe), 0);
    chk("R11 scan_busy low after abort", int'(scan_busy), 0);
    chk("R11 acq_busy low after abort", int'(acq_busy), 0);
    seen = n_ev;
    repeat (15) @(negedge clk);
    chk("R11 no strobe after abort", n_ev, seen);
    set_cfg(8, 2, 3, 1, 1'b0, 1);
    clear_log();
    trig(t);
    wait_idle();
    expect_run(t, 0, 3, 2, 8, 1, "R11 restart");
  endtask

  task automatic t_tbsel();
    for (int s = 0; s < 4; s++) begin
      int t;
      per_int = (s == 0) ? 3 : 1;
      per_ext = (s == 1) ? 3 : 1;
      per_ta  = (s == 2) ? 3 : 1;
      per_tb  = (s == 3) ? 3 : 1;
      tb_sel = 2'(s);
      set_cfg(3, 1, 2, 2, 1'b0, 1);
      clear_log();
      trig(t);
      wait_idle();
      chk("R1 strobe count", n_ev, 4);
      if (n_ev >= 4) begin
        chk("R1 sample spacing", ev_t[1] - ev_t[0], 3);
        chk("R1 scan spacing", ev_t[2] - ev_t[0], 9);
        chk("R1 first strobe within one period", (ev_t[0] - t >= 1 && ev_t[0] - t <= 3) ? 1 : 0, 1);
      end
    end
    per_int = 1; per_ext = 1; per_ta = 1; per_tb = 1;
    tb_sel = 2'd0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_post_trigger();
    t_delay();
    t_overrun();
    t_single_chan();
    t_cfg_err();
    t_retrig();
    t_abort();
    t_tbsel();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule